// File: doc/BRIEF.md
# External Interrupt Request Input Stage

This block sits between eight external, active-low interrupt pins and an interrupt priority arbiter. Every pin passes through a two-flop synchronizer. Each pin can then act as its own level-detected request, with a pending flag per pin. Either group of four pins can instead be used as an encoded priority-level input.

A control register holds a single level-handling bit. While that bit is 0, a detected request stays pending after its pin returns high. It stays pending until the CPU accepts any interrupt, until the source is masked, or until software clears it. While the bit is 1, each pending flag simply tracks the masked pin level. The encoded-level path does not depend on this bit. It reports the bitwise inverse of the selected four pins, and it changes only after the new value has been stable for two cycles.

Software reaches the block through a small write port. Address 0 is the pending register, where writing 0 to a bit clears that flag. Address 1 is the control register, where bit 0 is the level-handling bit.

Top module: `extint_front`

## Requirements
- R1: The level-handling bit (control address 1, bit 0) resets to 0, which selects the holding behaviour. A write to address 1 loads wrData[0] into it on the next clock edge.
- R2: A pin is active low. When a pin goes low before clock edge 1, its pending flag (pendFlags bit i for pin i) is set after edge 3, and not earlier.
- R3: With the level-handling bit at 0, a pending flag stays set after its pin returns high.
- R4: With the level-handling bit at 0, a one-cycle ackStrobe clears every held pending flag whose pin is no longer asserted.
- R5: Setting irqMask[i] clears pending flag i on the next edge. While irqMask[i] is set, an asserted pin i never sets flag i.
- R6: Writing to address 0 clears each pending flag whose wrData bit is 0, provided its pin is deasserted. Data bits that are 1 leave their flags unchanged.
- R7: With the level-handling bit at 0, writing 0 to a pending bit has no effect while that pin is still asserted.
- R8: With the level-handling bit at 1, a pending flag drops three edges after its pin returns high, with no hold.
- R9: When encEnable is 1, encLevel is the bitwise inverse of pins 7..4 (encUpper=1) or pins 3..0 (encUpper=0). All four pins low gives level 15, all high gives level 0. The pins of the selected group never set pending flags. The level-handling bit does not affect encLevel.
- R10: encLevel follows a pin change four edges after the pins change. A pin pattern held for only one cycle never reaches encLevel.
- R11: encLevel reads 0 whenever encMask is 1 or encEnable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinN | input | 8 | External interrupt pins, active low, asynchronous |
| irqMask | input | 8 | Per-pin request mask, 1 = masked |
| encMask | input | 1 | Mask for the encoded level, 1 = level forced to 0 |
| encEnable | input | 1 | Use one pin group as an encoded level input |
| encUpper | input | 1 | Group select for encoding: 1 = pins 7..4, 0 = pins 3..0 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register address: 0 = pending flags, 1 = control |
| wrData | input | 8 | Register write data |
| ackStrobe | input | 1 | CPU interrupt acceptance pulse |
| pendFlags | output | 8 | Per-pin pending flags to the arbiter |
| encLevel | output | 4 | Encoded priority level, 0 = no request |

## Verification
The hardest situation to reach is a software clear that arrives while the pin is still low in holding mode. The pin must be held asserted across the write, so that recapture and the clear meet on the same edge. A second hard case is a pin pattern on the encoded group that lasts exactly one cycle, which has to be filtered out. The bench drives the pins at the falling edge and holds them for a counted number of cycles. It first builds a held flag, then re-asserts the pin and issues the write mid-assertion. For the filter, it inserts a single-cycle glitch pattern between two stable levels and checks encLevel both before and after the four-edge latency.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int PIN_CNT  = 8;
  localparam int GRP_W    = 4;
  localparam int GRP_CNT  = PIN_CNT / GRP_W;
  localparam int GRP_SELW = (GRP_CNT > 1) ? $clog2(GRP_CNT) : 1;
  localparam int WR_PEND  = 0;
  localparam int WR_CFG   = 1;

  typedef struct packed {
    logic                retain;
    logic                ackRelease;
    logic [PIN_CNT-1:0]  swClear;
    logic [PIN_CNT-1:0]  encOwned;
    logic                encActive;
    logic [GRP_SELW-1:0] grpSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [PIN_CNT-1:0] wrData,
  input  logic               ackStrobe,
  input  logic               encEnable,
  input  logic               encUpper,
  output ctrlStrobe_t        strb
);
  logic levelModeQ;
  logic cfgWrite;
  logic pendWrite;
  logic [GRP_SELW-1:0] grpSel;

  assign cfgWrite  = wrEn && (wrAddr == 1'(WR_CFG));
  assign pendWrite = wrEn && (wrAddr == 1'(WR_PEND));
  assign grpSel    = GRP_SELW'(encUpper);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         levelModeQ <= 1'b0;
    else if (cfgWrite) levelModeQ <= wrData[0];
  end

  logic [PIN_CNT-1:0] ownedMask;
  genvar g;
  generate
    for (g = 0; g < GRP_CNT; g++) begin : g_own
      assign ownedMask[g*GRP_W +: GRP_W] =
        {GRP_W{encEnable && (grpSel == GRP_SELW'(g))}};
    end
  endgenerate

  always_comb begin
    strb            = '0;
    strb.retain     = !levelModeQ;
    strb.ackRelease = ackStrobe;
    strb.swClear    = pendWrite ? ~wrData : '0;
    strb.encOwned   = ownedMask;
    strb.encActive  = encEnable;
    strb.grpSel     = grpSel;
  end

  // R1: a control write lands in the holding selection one edge later
  a_r1_mode_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (strb.retain == !$past(wrData[0])));
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinSync,
  input  logic [PIN_CNT-1:0] irqMask,
  input  logic               encMask,
  input  ctrlStrobe_t        strb,
  output logic [PIN_CNT-1:0] pendFlags,
  output logic [GRP_W-1:0]   encLevel
);
  logic [PIN_CNT-1:0] pendQ;
  logic [PIN_CNT-1:0] reqLvl;
  logic [PIN_CNT-1:0] pendNext;

  genvar i;
  generate
    for (i = 0; i < PIN_CNT; i++) begin : g_pin
      assign reqLvl[i] = !pinSync[i] && !irqMask[i] && !strb.encOwned[i];
      always_comb begin
        if (strb.retain)
          pendNext[i] = reqLvl[i] ||
                        (pendQ[i] && !strb.ackRelease && !strb.swClear[i] &&
                         !irqMask[i] && !strb.encOwned[i]);
        else
          pendNext[i] = reqLvl[i];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pendQ[i] <= 1'b0;
        else       pendQ[i] <= pendNext[i];
      end
    end
  endgenerate

  assign pendFlags = pendQ;

  logic [GRP_W-1:0] grpPins;
  logic [GRP_W-1:0] rawLvl;
  logic [GRP_W-1:0] prevRaw;
  logic [GRP_W-1:0] encReg;

  always_comb begin
    grpPins = '1;
    for (int g = 0; g < GRP_CNT; g++)
      if (strb.grpSel == GRP_SELW'(g)) grpPins = pinSync[g*GRP_W +: GRP_W];
  end

  assign rawLvl = ~grpPins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRaw <= '0;
      encReg  <= '0;
    end else begin
      prevRaw <= rawLvl;
      if (!strb.encActive)        encReg <= '0;
      else if (rawLvl == prevRaw) encReg <= rawLvl;
    end
  end

  assign encLevel = (strb.encActive && !encMask) ? encReg : '0;

  // R5: a masked source is clear on the following edge
  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (|irqMask) |=> ((pendQ & $past(irqMask)) == '0));

  // R3: in holding mode a flag only falls through a release cause
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retain && !strb.ackRelease) |=>
      (($past(pendQ & ~irqMask & ~strb.swClear & ~strb.encOwned) & ~pendQ) == '0));

  // R9: pins owned by the encoded group never raise a flag
  a_r9_owned_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.encOwned) |=> ((pendQ & $past(strb.encOwned)) == '0));

  // R10: the captured level only moves after two equal samples
  a_r10_stable_level: assert property (@(posedge clk) disable iff (!rstN)
    (strb.encActive && $past(strb.encActive) && !$stable(encReg)) |->
      ($past(rawLvl) == $past(rawLvl, 2)));
endmodule

// File: rtl/extint_front.sv
module extint_front
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinN,
  input  logic [PIN_CNT-1:0] irqMask,
  input  logic               encMask,
  input  logic               encEnable,
  input  logic               encUpper,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [PIN_CNT-1:0] wrData,
  input  logic               ackStrobe,
  output logic [PIN_CNT-1:0] pendFlags,
  output logic [GRP_W-1:0]   encLevel
);
  logic [PIN_CNT-1:0] pinSync;
  ctrlStrobe_t        strb;

  extint_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(pinN), .syncOut(pinSync)
  );

  extint_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ackStrobe(ackStrobe), .encEnable(encEnable), .encUpper(encUpper),
    .strb(strb)
  );

  extint_datapath dp_i (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .irqMask(irqMask),
    .encMask(encMask), .strb(strb), .pendFlags(pendFlags), .encLevel(encLevel)
  );
endmodule

// File: tb/extint_front_tb_top.sv
module extint_front_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinN;
  logic [7:0] irqMask;
  logic       encMask, encEnable, encUpper;
  logic       wrEn, wrAddr;
  logic [7:0] wrData;
  logic       ackStrobe;
  logic [7:0] pendFlags;
  logic [3:0] encLevel;

  int vecCnt  = 0;
  int failCnt = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  extint_front dut_i (
    .clk(clk), .rstN(rstN), .pinN(pinN), .irqMask(irqMask), .encMask(encMask),
    .encEnable(encEnable), .encUpper(encUpper), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ackStrobe(ackStrobe), .pendFlags(pendFlags),
    .encLevel(encLevel)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic addr, input logic [7:0] data);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    step(1);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1 reset pend", pendFlags, 8'h00);
    chk("R11 reset level", {4'h0, encLevel}, 8'h00);
  endtask

  task automatic t_hold();
    pinN[2] = 1'b0;
    step(2);
    chk("R2 not before edge 3", pendFlags, 8'h00);
    step(1);
    chk("R2 set after edge 3", pendFlags, 8'h04);
    pinN[2] = 1'b1;
    step(5);
    chk("R3 R1 held after release", pendFlags, 8'h04);
  endtask

  task automatic t_clear_while_active();
    pinN[2] = 1'b0;
    step(3);
    regWrite(1'b0, 8'hFB);
    chk("R7 write 0 while asserted", pendFlags, 8'h04);
    pinN[2] = 1'b1;
    step(3);
    chk("R7 still held", pendFlags, 8'h04);
  endtask

  task automatic t_swclear();
    regWrite(1'b0, 8'hFF);
    chk("R6 ones no effect", pendFlags, 8'h04);
    regWrite(1'b0, 8'hFB);
    chk("R6 zero clears", pendFlags, 8'h00);
  endtask

  task automatic t_ack();
    pinN[1] = 1'b0; pinN[5] = 1'b0;
    step(3);
    pinN[1] = 1'b1; pinN[5] = 1'b1;
    step(3);
    chk("R4 both held", pendFlags, 8'h22);
    ackStrobe = 1'b1;
    step(1);
    ackStrobe = 1'b0;
    chk("R4 ack releases all", pendFlags, 8'h00);
  endtask

  task automatic t_mask();
    pinN[3] = 1'b0;
    step(3);
    pinN[3] = 1'b1;
    step(3);
    chk("R5 held before mask", pendFlags, 8'h08);
    irqMask[3] = 1'b1;
    step(1);
    chk("R5 mask clears", pendFlags, 8'h00);
    pinN[3] = 1'b0;
    step(4);
    chk("R5 masked never sets", pendFlags, 8'h00);
    irqMask[3] = 1'b0;
    step(1);
    chk("R5 unmask recaptures", pendFlags, 8'h08);
    pinN[3] = 1'b1;
    step(3);
    regWrite(1'b0, 8'hF7);
    chk("R6 cleanup", pendFlags, 8'h00);
  endtask

  task automatic t_passthru();
    regWrite(1'b1, 8'h01);
    pinN[4] = 1'b0;
    step(3);
    chk("R8 follows assert", pendFlags, 8'h10);
    pinN[4] = 1'b1;
    step(2);
    chk("R8 still up before edge 3", pendFlags, 8'h10);
    step(1);
    chk("R8 drops without hold", pendFlags, 8'h00);
  endtask

  task automatic t_encoded();
    encEnable = 1'b1; encUpper = 1'b0;
    pinN[3:0] = 4'b0000;
    step(6);
    chk("R9 all low is 15", {4'h0, encLevel}, 8'h0F);
    chk("R9 owned pins quiet", pendFlags, 8'h00);
    pinN[3:0] = 4'b1010;
    step(6);
    chk("R9 lower inverse", {4'h0, encLevel}, 8'h05);
    pinN[3:0] = 4'b1111;
    encUpper = 1'b1;
    pinN[7:4] = 4'b0011;
    step(6);
    chk("R9 upper inverse", {4'h0, encLevel}, 8'h0C);
    chk("R9 upper owned quiet", pendFlags, 8'h00);
    regWrite(1'b1, 8'h00);
    step(2);
    chk("R9 mode bit no effect", {4'h0, encLevel}, 8'h0C);
  endtask

  task automatic t_glitch();
    pinN[7:4] = 4'b0000;
    step(1);
    pinN[7:4] = 4'b0011;
    step(6);
    chk("R10 glitch filtered", {4'h0, encLevel}, 8'h0C);
    pinN[7:4] = 4'b1110;
    step(3);
    chk("R10 old level at edge 3", {4'h0, encLevel}, 8'h0C);
    step(1);
    chk("R10 new level at edge 4", {4'h0, encLevel}, 8'h01);
  endtask

  task automatic t_encmask();
    encMask = 1'b1;
    step(1);
    chk("R11 masked level", {4'h0, encLevel}, 8'h00);
    encMask = 1'b0;
    step(1);
    chk("R11 unmasked back", {4'h0, encLevel}, 8'h01);
    encEnable = 1'b0;
    step(1);
    chk("R11 disabled level", {4'h0, encLevel}, 8'h00);
    pinN = 8'hFF;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0; pinN = 8'hFF; irqMask = 8'h00; encMask = 1'b0;
    encEnable = 1'b0; encUpper = 1'b0; wrEn = 1'b0; wrAddr = 1'b0;
    wrData = 8'h00; ackStrobe = 1'b0;
    step(3);
    rstN = 1'b1;
    step(2);
    t_reset();
    t_hold();
    t_clear_while_active();
    t_swclear();
    t_ack();
    t_mask();
    t_passthru();
    t_encoded();
    t_glitch();
    t_encmask();
    step(2);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule